// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns an SDRAM command bus from reset until the memory can take normal traffic. Straight out of reset it keeps clock-enable and the data mask high and presents only no-operation commands. It holds that state for a settle interval, given in microseconds and turned into clock cycles by a clock-frequency parameter. It then issues one precharge that covers all banks. After that come a configurable number of auto-refresh commands and a single mode-register write, in an order chosen by a parameter. Every command is followed by a parameterized stretch of NOP cycles for the matching memory timing. When the last gap expires, a ready flag rises and stays high.

The mode word is built at elaboration time from four parameters: burst length code, burst type, CAS latency code and write-burst behaviour. The test-mode and reserved positions are always forced to zero. An illegal parameter combination is caught before any command goes out. In that case the block raises an error flag, keeps the bus idle and never asserts ready. All pins are plain control outputs, with no handshake, because the block has no data stream.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is held and after it, until the settle interval ends, the bus carries NOP, encoded {cs_n,ras_n,cas_n,we_n}=0111, with addr and ba at 0 and ready at 0.
- R2: Exactly CLK_MHZ*WAIT_US NOP cycles are seen, counted from the first cycle after reset release, before the first other command.
- R3: The first command after the settle interval is precharge (0111 replaced by 0010) with addr bit 10 at 1, every other addr bit at 0 and ba at 0, followed by exactly T_RP NOP cycles.
- R4: Exactly REFRESH_COUNT auto-refresh commands (0001, addr and ba 0) are issued, each followed by exactly T_RFC NOP cycles.
- R5: One mode-register write (0000, ba 0, addr carrying the mode word) is issued and is followed by exactly T_MRD NOP cycles.
- R6: With MODE_FIRST=0 the refreshes come before the mode write. With MODE_FIRST=1 the mode write comes right after the precharge gap, and the refreshes follow it. Ready rises in the cycle after the last gap of the sequence.
- R7: The mode word carries the burst length code in bits 2:0, the burst type in bit 3 (1 = interleaved), the CAS latency code in bits 6:4 and the write mode in bit 9 (1 = single-location write). Bits 8:7 and every bit from 10 up are 0.
- R8: Burst length codes 0 to 3 are legal with either burst type, and code 7 is legal only with sequential type. CAS latency codes 2 and 3 are the only legal ones. On any other combination, cfg_error is 1 from the first clock edge after reset release onward, the bus stays NOP and ready never rises.
- R9: Once ready is 1 it stays 1 and the bus stays NOP.
- R10: cke and dqm are 1 in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | output | 1 | Clock enable to the memory |
| dqm | output | 1 | Data mask to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address pins (precharge-all flag, mode word) |
| ba | output | BANK_W | Bank address pins |
| ready | output | 1 | Initialization finished |
| cfg_error | output | 1 | Mode parameters are illegal |

## Verification
The bench compresses the bus into runs of identical commands and compares each run, including its exact length, against a schedule built from the parameters. An off-by-one gap counter therefore shows up as a NOP run that is one cycle short or long. It runs both orderings side by side, with a different refresh count in each. A sequencer that ignores the order parameter, or stops one refresh early, would emit runs in the wrong order or too few of them. One instance uses a full-page burst with a single-location write, so a mode word with a field in the wrong position or a stray reserved bit would miscompare. Two instances carry illegal settings, full page with interleave and a reserved latency code. A design with a weak legality test would start issuing commands or raise ready on them.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } bus_cmd_e;

  typedef enum logic [3:0] {
    ST_SETTLE,
    ST_PRE,
    ST_PRE_GAP,
    ST_REF,
    ST_REF_GAP,
    ST_MRS,
    ST_MRS_GAP,
    ST_READY,
    ST_FAULT
  } init_step_e;

  localparam int PRE_ALL_BIT = 10;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic burst_ok(input logic [2:0] len_code, input logic interleave);
    return (len_code <= 3'd3) || ((len_code == 3'd7) && !interleave);
  endfunction

  function automatic logic latency_ok(input logic [2:0] lat_code);
    return (lat_code == 3'd2) || (lat_code == 3'd3);
  endfunction

endpackage

// File: rtl/sdram_mode_word.sv
module sdram_mode_word
  import sdram_init_pkg::*;
#(
  parameter int         ADDR_W           = 12,
  parameter logic [2:0] BL_CODE          = 3'd3,
  parameter logic       BURST_INTERLEAVE = 1'b0,
  parameter logic [2:0] CL_CODE          = 3'd3,
  parameter logic       WRITE_SINGLE     = 1'b0
) (
  output logic [ADDR_W-1:0] word,
  output logic              legal
);

  always_comb begin
    word      = '0;
    word[2:0] = BL_CODE;
    word[3]   = BURST_INTERLEAVE;
    word[6:4] = CL_CODE;
    word[8:7] = 2'b00;
    word[9]   = WRITE_SINGLE;
  end

  assign legal = burst_ok(BL_CODE, BURST_INTERLEAVE) && latency_ok(CL_CODE);

endmodule

// File: rtl/sdram_gap_timer.sv
module sdram_gap_timer #(
  parameter int CNT_W    = 8,
  parameter int INIT_VAL = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= CNT_W'(INIT_VAL);
    else if (load)          cnt <= load_val;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/sdram_init_steps.sv
module sdram_init_steps
  import sdram_init_pkg::*;
#(
  parameter int   REFRESH_COUNT = 2,
  parameter int   T_RP          = 3,
  parameter int   T_RFC         = 9,
  parameter int   T_MRD         = 2,
  parameter logic MODE_FIRST    = 1'b0,
  parameter int   CNT_W         = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             legal,
  input  logic             expired,
  output init_step_e       step,
  output logic             load,
  output logic [CNT_W-1:0] load_val
);

  localparam int RW = $clog2(REFRESH_COUNT + 1);
  localparam logic [RW-1:0] REF_TOTAL = RW'(REFRESH_COUNT);

  logic [RW-1:0] refs_done;
  logic          mode_done;

  always_comb begin
    load     = 1'b0;
    load_val = '0;
    case (step)
      ST_PRE: begin load = 1'b1; load_val = CNT_W'(T_RP - 1);  end
      ST_REF: begin load = 1'b1; load_val = CNT_W'(T_RFC - 1); end
      ST_MRS: begin load = 1'b1; load_val = CNT_W'(T_MRD - 1); end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step      <= ST_SETTLE;
      refs_done <= '0;
      mode_done <= 1'b0;
    end else begin
      case (step)
        ST_SETTLE: begin
          if (!legal)       step <= ST_FAULT;
          else if (expired) step <= ST_PRE;
        end
        ST_PRE: step <= ST_PRE_GAP;
        ST_PRE_GAP: begin
          if (expired) step <= MODE_FIRST ? ST_MRS : ST_REF;
        end
        ST_REF: begin
          refs_done <= refs_done + 1'b1;
          step      <= ST_REF_GAP;
        end
        ST_REF_GAP: begin
          if (expired) begin
            if (refs_done < REF_TOTAL) step <= ST_REF;
            else if (mode_done)        step <= ST_READY;
            else                       step <= ST_MRS;
          end
        end
        ST_MRS: begin
          mode_done <= 1'b1;
          step      <= ST_MRS_GAP;
        end
        ST_MRS_GAP: begin
          if (expired) step <= (refs_done == REF_TOTAL) ? ST_READY : ST_REF;
        end
        ST_READY: step <= ST_READY;
        default:  step <= ST_FAULT;
      endcase
    end
  end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int         ADDR_W           = 12,
  parameter int         BANK_W           = 2,
  parameter int         CLK_MHZ          = 125,
  parameter int         WAIT_US          = 200,
  parameter int         REFRESH_COUNT    = 2,
  parameter int         T_RP             = 3,
  parameter int         T_RFC            = 9,
  parameter int         T_MRD            = 2,
  parameter logic       MODE_FIRST       = 1'b0,
  parameter logic [2:0] BL_CODE          = 3'd3,
  parameter logic       BURST_INTERLEAVE = 1'b0,
  parameter logic [2:0] CL_CODE          = 3'd3,
  parameter logic       WRITE_SINGLE     = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              cke,
  output logic              dqm,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] ba,
  output logic              ready,
  output logic              cfg_error
);

  localparam int WAIT_CYC = CLK_MHZ * WAIT_US;
  localparam int MAX_CNT  = imax(imax(WAIT_CYC, T_RP), imax(T_RFC, T_MRD));
  localparam int CNT_W    = $clog2(MAX_CNT + 1) + 1;

  logic [ADDR_W-1:0] mode_word;
  logic              mode_legal;
  logic              gap_expired;
  logic              gap_load;
  logic [CNT_W-1:0]  gap_val;
  init_step_e        step;
  bus_cmd_e          cmd;

  sdram_mode_word #(
    .ADDR_W(ADDR_W), .BL_CODE(BL_CODE), .BURST_INTERLEAVE(BURST_INTERLEAVE),
    .CL_CODE(CL_CODE), .WRITE_SINGLE(WRITE_SINGLE)
  ) u_word (
    .word(mode_word), .legal(mode_legal)
  );

  sdram_gap_timer #(.CNT_W(CNT_W), .INIT_VAL(WAIT_CYC - 1)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(gap_load), .load_val(gap_val), .expired(gap_expired)
  );

  sdram_init_steps #(
    .REFRESH_COUNT(REFRESH_COUNT), .T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD),
    .MODE_FIRST(MODE_FIRST), .CNT_W(CNT_W)
  ) u_steps (
    .clk(clk), .rst_n(rst_n), .legal(mode_legal), .expired(gap_expired),
    .step(step), .load(gap_load), .load_val(gap_val)
  );

  always_comb begin
    cmd  = CMD_NOP;
    addr = '0;
    ba   = '0;
    case (step)
      ST_PRE: begin cmd = CMD_PRE; addr[PRE_ALL_BIT] = 1'b1; end
      ST_REF: cmd = CMD_REF;
      ST_MRS: begin cmd = CMD_MRS; addr = mode_word; end
      default: ;
    endcase
  end

  assign {cs_n, ras_n, cas_n, we_n} = cmd;
  assign cke       = 1'b1;
  assign dqm       = 1'b1;
  assign ready     = (step == ST_READY);
  assign cfg_error = (step == ST_FAULT);

endmodule

// File: rtl/sdram_init_chk.sv
module sdram_init_chk #(
  parameter int ADDR_W = 12,
  parameter int BANK_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cke,
  input logic              dqm,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [ADDR_W-1:0] addr,
  input logic [BANK_W-1:0] ba,
  input logic              ready,
  input logic              cfg_error
);

  logic [3:0] bus;
  assign bus = {cs_n, ras_n, cas_n, we_n};

  // R10
  pins_high_chk: assert property (@(posedge clk) disable iff (!rst_n) cke && dqm);

  // R9
  ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) ready |=> ready);

  // R9
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) ready |-> bus == 4'b0111);

  // R8
  fault_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_error |-> (bus == 4'b0111) && !ready);

  // R3
  pre_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus == 4'b0010) |-> addr[10] && (ba == '0));

  // R5
  mrs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus == 4'b0000) |=> (bus == 4'b0111) && !ready);

  // R7
  mrs_resv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus == 4'b0000) |-> (addr[8:7] == 2'b00) && (addr[ADDR_W-1:10] == '0) && (ba == '0));

endmodule

bind sdram_init_seq sdram_init_chk #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cke(cke), .dqm(dqm), .cs_n(cs_n), .ras_n(ras_n),
  .cas_n(cas_n), .we_n(we_n), .addr(addr), .ba(ba), .ready(ready), .cfg_error(cfg_error)
);

// File: tb/sim_sdram_init_seq.sv
`timescale 1ns/1ps
module sim_sdram_init_seq;

  localparam logic [3:0] NOP = 4'b0111, PRE = 4'b0010, REF = 4'b0001, MRS = 4'b0000;

  typedef struct {
    logic [3:0]  cmd;
    logic [11:0] addr;
    int          len;
    string       tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mon_on = 1'b0;
  always #4 clk = ~clk;

  logic [3:0]  mcmd [4];
  logic [11:0] maddr[4];
  logic [1:0]  mba  [4];
  logic        mcke [4], mdqm[4], mrdy[4], merr[4];

  int errors = 0, checks = 0;
  item_t expq[2][$];
  logic [3:0]  cur_cmd [2];
  logic [11:0] cur_addr[2];
  int  cur_len[2];
  bit  done[2];
  int  hold_viol[2];
  int  pin_viol = 0, fault_viol[4], samp = 0;

  for (genvar g = 0; g < 4; g++) begin : g_inst
    localparam logic [2:0] BLC = (g == 0) ? 3'd3 : (g == 3) ? 3'd2 : 3'd7;
    localparam logic [2:0] CLC = (g == 1) ? 3'd2 : (g == 3) ? 3'd1 : 3'd3;
    logic cs, ras, cas, we;
    if (g == 0) begin : g_u
      sdram_init_seq #(.CLK_MHZ(1), .WAIT_US(20), .REFRESH_COUNT(2), .T_RP(2), .T_RFC(5),
        .T_MRD(3), .MODE_FIRST(1'b0), .BL_CODE(BLC), .BURST_INTERLEAVE(1'b0),
        .CL_CODE(CLC), .WRITE_SINGLE(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .cke(mcke[g]), .dqm(mdqm[g]), .cs_n(cs), .ras_n(ras),
        .cas_n(cas), .we_n(we), .addr(maddr[g]), .ba(mba[g]), .ready(mrdy[g]), .cfg_error(merr[g]));
    end else if (g == 1) begin : g_u
      sdram_init_seq #(.CLK_MHZ(2), .WAIT_US(7), .REFRESH_COUNT(3), .T_RP(1), .T_RFC(4),
        .T_MRD(2), .MODE_FIRST(1'b1), .BL_CODE(BLC), .BURST_INTERLEAVE(1'b0),
        .CL_CODE(CLC), .WRITE_SINGLE(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .cke(mcke[g]), .dqm(mdqm[g]), .cs_n(cs), .ras_n(ras),
        .cas_n(cas), .we_n(we), .addr(maddr[g]), .ba(mba[g]), .ready(mrdy[g]), .cfg_error(merr[g]));
    end else begin : g_u
      sdram_init_seq #(.CLK_MHZ(1), .WAIT_US(10), .BL_CODE(BLC),
        .BURST_INTERLEAVE(g == 2), .CL_CODE(CLC)) ux (
        .clk(clk), .rst_n(rst_n), .cke(mcke[g]), .dqm(mdqm[g]), .cs_n(cs), .ras_n(ras),
        .cas_n(cas), .we_n(we), .addr(maddr[g]), .ba(mba[g]), .ready(mrdy[g]), .cfg_error(merr[g]));
    end
    assign mcmd[g] = {cs, ras, cas, we};
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [11:0] mk_word(input logic [2:0] bl, input logic il,
                                          input logic [2:0] cl, input logic ws);
    return (12'(ws) << 9) | (12'(cl) << 4) | (12'(il) << 3) | 12'(bl);
  endfunction

  task automatic push(input int i, input logic [3:0] c, input logic [11:0] a,
                      input int n, input string tag);
    item_t it;
    it.cmd = c; it.addr = a; it.len = n; it.tag = tag;
    expq[i].push_back(it);
  endtask

  task automatic plan(input int i, input int wcyc, input int nref, input int trp,
                      input int trfc, input int tmrd, input bit mfirst, input logic [11:0] w);
    push(i, NOP, 12'h000, wcyc, "R2 settle");
    push(i, PRE, 12'h400, 1, "R3 precharge");
    push(i, NOP, 12'h000, trp, "R3 tRP gap");
    if (mfirst) begin
      push(i, MRS, w, 1, "R6 R7 mode write first");
      push(i, NOP, 12'h000, tmrd, "R5 tMRD gap");
    end
    for (int k = 0; k < nref; k++) begin
      push(i, REF, 12'h000, 1, "R4 refresh");
      push(i, NOP, 12'h000, trfc, "R4 tRFC gap");
    end
    if (!mfirst) begin
      push(i, MRS, w, 1, "R5 R7 mode write last");
      push(i, NOP, 12'h000, tmrd, "R5 tMRD gap");
    end
  endtask

  task automatic close_run(input int i);
    item_t it;
    if (expq[i].size() == 0) begin
      chk(1'b0, "R6", "unexpected extra command run", 32'(cur_cmd[i]), 32'hF);
      return;
    end
    it = expq[i].pop_front();
    chk(cur_cmd[i] == it.cmd, it.tag, "command", 32'(cur_cmd[i]), 32'(it.cmd));
    chk(cur_addr[i] == it.addr, it.tag, "address", 32'(cur_addr[i]), 32'(it.addr));
    chk(cur_len[i] == it.len, it.tag, "run length", 32'(cur_len[i]), 32'(it.len));
  endtask

  // monitor: run-length compresses each sequenced bus and scores it
  always @(negedge clk) begin
    if (mon_on) begin
      for (int i = 0; i < 2; i++) begin
        if (!done[i]) begin
          if (mrdy[i]) begin
            if (cur_len[i] > 0) close_run(i);
            chk(expq[i].size() == 0, "R6", "runs missing when ready rose",
                32'(expq[i].size()), 32'd0);
            done[i] = 1'b1;
          end else if (cur_len[i] > 0 && mcmd[i] == cur_cmd[i] &&
                       maddr[i] == cur_addr[i] && mba[i] == 2'b00) begin
            cur_len[i]++;
          end else begin
            if (cur_len[i] > 0) close_run(i);
            cur_cmd[i] = mcmd[i]; cur_addr[i] = maddr[i]; cur_len[i] = 1;
            if (mba[i] != 2'b00) cur_addr[i] = 12'hFFF;
          end
        end else if (!mrdy[i] || mcmd[i] != NOP) begin
          hold_viol[i]++;
        end
      end
      for (int i = 0; i < 4; i++) begin
        if (!(mcke[i] && mdqm[i])) pin_viol++;
        if (i >= 2 && samp > 0 &&
            (!merr[i] || mrdy[i] || mcmd[i] != NOP || maddr[i] != '0)) fault_viol[i]++;
      end
      samp++;
    end
  end

  initial begin
    bit finished;
    for (int i = 0; i < 2; i++) begin
      cur_len[i] = 0; done[i] = 1'b0; hold_viol[i] = 0;
    end
    for (int i = 0; i < 4; i++) fault_viol[i] = 0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      chk(mcmd[i] == NOP, "R1", "reset command", 32'(mcmd[i]), 32'(NOP));
      chk(maddr[i] == '0 && mba[i] == '0, "R1", "reset addr/ba",
          32'({maddr[i], mba[i]}), 32'd0);
      chk(!mrdy[i], "R1", "reset ready", 32'(mrdy[i]), 32'd0);
      chk(mcke[i] && mdqm[i], "R10", "reset cke/dqm", 32'({mcke[i], mdqm[i]}), 32'd3);
    end
    plan(0, 20, 2, 2, 5, 3, 1'b0, mk_word(3'd3, 1'b0, 3'd3, 1'b0));
    plan(1, 14, 3, 1, 4, 2, 1'b1, mk_word(3'd7, 1'b0, 3'd2, 1'b1));
    @(posedge clk);
    #2;
    rst_n = 1'b1;
    mon_on = 1'b1;
    finished = 1'b0;
    for (int c = 0; c < 5000; c++) begin
      @(negedge clk);
      if (done[0] && done[1]) begin finished = 1'b1; break; end
    end
    chk(finished, "R6", "watchdog: ready not reached", 32'({done[0], done[1]}), 32'd3);
    repeat (30) @(negedge clk);
    #1;
    chk(hold_viol[0] == 0, "R9", "u0 ready/NOP hold", 32'(hold_viol[0]), 32'd0);
    chk(hold_viol[1] == 0, "R9", "u1 ready/NOP hold", 32'(hold_viol[1]), 32'd0);
    chk(pin_viol == 0, "R10", "cke/dqm low seen", 32'(pin_viol), 32'd0);
    chk(fault_viol[2] == 0, "R8", "full page interleave not idle/faulted",
        32'(fault_viol[2]), 32'd0);
    chk(fault_viol[3] == 0, "R8", "reserved latency not idle/faulted",
        32'(fault_viol[3]), 32'd0);
    chk(merr[2] && merr[3], "R8", "error flags", 32'({merr[2], merr[3]}), 32'd3);
    chk(!merr[0] && !merr[1], "R8", "legal setups flagged", 32'({merr[0], merr[1]}), 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule